// File: doc/BRIEF.md
# Interleaved NAND array write scheduler

The scheduler takes a steady stream of image words and writes them, page by page, into a grid of NAND flash devices without ever pushing back on the source. Each row of the grid holds several byte-wide devices driven side by side, so one bus cycle carries a full word made of one byte per device. Rows take turns. While the row that was just loaded is still programming, the next row is already being loaded. A page therefore meets a busy device only when the whole rotation comes back to that row before its program has finished.

Incoming words first enter a small first-in first-out queue. From there they move into one of two page banks. One bank fills while the other drains to the flash bus. The flash side issues a program command, a column address cycle, a row address cycle, one data cycle per word and a confirm command. The page and block positions advance after each full rotation of rows. Blocks that an external bad-block map marks as unusable are skipped for all rows together. A sticky overflow flag reports any word that arrives while the queue is full.

Top module: `nand_stripe_writer`

## Requirements
- R1: After reset, flash_we, flash_cle, flash_ale and every flash_ce bit are low and overflow is low. Writing starts at row 0, page 0 of block 0, and block 0 is taken as usable.
- R2: Every page is written as exactly PAGE_WORDS+4 consecutive flash_we cycles in this order: a command cycle (cle=1) carrying 8'h80 on every byte lane, a column address cycle (ale=1) carrying zero, a row address cycle (ale=1), PAGE_WORDS data cycles (cle=0, ale=0), and a command cycle (cle=1) carrying 8'h10 on every byte lane.
- R3: A word presented while the input queue already holds FIFO_DEPTH words is dropped, and overflow rises on the next cycle. Overflow then stays high until reset. A dropped word never appears on the flash bus.
- R4: Data words reach flash_io unchanged and in arrival order. Each page carries the next PAGE_WORDS words, and the least significant byte goes to device lane 0.
- R5: Pages go to rows 0, 1, ..., NUM_ROWS-1 and then wrap to row 0. During a page, exactly the flash_ce bit of the target row is high.
- R6: A page is started on a row only when that row's flash_ready input is high. After a confirm, the row is not used again until its flash_ready has first been seen low.
- R7: The row address byte, replicated on every lane, equals block*PAGES_PER_BLOCK+page. The page index advances after each full rotation of rows. After PAGES_PER_BLOCK rotations the page index returns to 0 and the block changes.
- R8: When the block changes, it moves to the next block, searching upward with wrap-around, whose bit in bad_block_map is 0 (1 marks an unusable block). The same block is used for every row.
- R9: With default parameters, one input word every two cycles and programs that hold flash_ready low for 30 cycles, every word is written and overflow stays low.
- R10: While all rows are busy, no flash_we cycle occurs. In that state the block absorbs 2*PAGE_WORDS+FIFO_DEPTH words without overflow and writes them all once rows become ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | NUM_LANES*8 | Input image word |
| bad_block_map | input | NUM_BLOCKS | One bit per block; 1 marks an unusable block |
| flash_ready | input | NUM_ROWS | Per-row ready/busy, 1 = ready |
| flash_ce | output | NUM_ROWS | One-hot row select during a page |
| flash_we | output | 1 | Bus cycle strobe |
| flash_cle | output | 1 | Cycle carries a command |
| flash_ale | output | 1 | Cycle carries an address |
| flash_io | output | NUM_LANES*8 | Command, address or data, one byte per device lane |
| overflow | output | 1 | Sticky: a word was dropped because the queue was full |

## Verification
The block is driven with an even stream at one word every two cycles, with one row's first program stretched by 40 cycles. This shows that the rotation waits on ready/busy without losing data. It is also driven with back-to-back bursts of three pages separated by idle gaps, and with a bad-block map that leaves only block 0 usable. That case exercises the wrap-around search and repeated reuse of one block. A run with every row held busy fills both buffer levels exactly to capacity, while a second run adds one more word. Comparing the two separates correct capacity from early overflow and shows that the dropped word never reaches flash. On every bus cycle, a reference model in the bench checks the command order, the row select, the row address and each data word.

// File: rtl/nsw_pkg.sv
package nsw_pkg;

    localparam int LANE_W = 8;

    localparam logic [LANE_W-1:0] OP_PROGRAM = 8'h80;
    localparam logic [LANE_W-1:0] OP_CONFIRM = 8'h10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_COL,
        ST_ROWA,
        ST_DATA,
        ST_CONF
    } seq_state_e;

    typedef struct packed {
        logic we;
        logic cle;
        logic ale;
    } bus_ctl_t;

    function automatic int clog2_min1(input int v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction

endpackage

// File: rtl/nsw_fifo.sv
module nsw_fifo
    import nsw_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_valid,
    input  logic [WIDTH-1:0] push_data,
    output logic             pop_valid,
    output logic [WIDTH-1:0] pop_data,
    input  logic             pop_ready,
    output logic             overflow
);
    localparam int PTR_W = clog2_min1(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] count_q;
    logic             full, do_push, do_pop;

    assign full      = (count_q == CNT_W'(DEPTH));
    assign pop_valid = (count_q != '0);
    assign pop_data  = mem[rptr_q];
    assign do_push   = push_valid && !full;
    assign do_pop    = pop_valid && pop_ready;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q   <= '0;
            rptr_q   <= '0;
            count_q  <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) wptr_q <= bump(wptr_q);
            if (do_pop)  rptr_q <= bump(rptr_q);
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
            if (push_valid && full) overflow <= 1'b1;
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R3
    AST_OVF_ON_FULL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (push_valid && full) |=> overflow); // R3

endmodule

// File: rtl/nsw_pingpong.sv
module nsw_pingpong #(
    parameter int WIDTH      = 16,
    parameter int PAGE_WORDS = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_valid,
    input  logic [WIDTH-1:0]               wr_data,
    output logic                           wr_ready,
    input  logic [nsw_pkg::clog2_min1(PAGE_WORDS)-1:0] rd_idx,
    output logic [WIDTH-1:0]               rd_data,
    output logic                           page_rdy,
    input  logic                           page_done
);
    localparam int IDX_W = nsw_pkg::clog2_min1(PAGE_WORDS);

    logic [1:0]       full_q;
    logic             fill_sel_q, drain_sel_q;
    logic [IDX_W-1:0] fill_idx_q;
    logic             take;
    logic [WIDTH-1:0] bank_rd [2];

    assign wr_ready = !full_q[fill_sel_q];
    assign take     = wr_valid && wr_ready;
    assign page_rdy = full_q[drain_sel_q];
    assign rd_data  = bank_rd[drain_sel_q];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [WIDTH-1:0] words [PAGE_WORDS];
        always_ff @(posedge clk) begin
            if (take && (fill_sel_q == 1'(b))) words[fill_idx_q] <= wr_data;
        end
        assign bank_rd[b] = words[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q      <= '0;
            fill_sel_q  <= 1'b0;
            drain_sel_q <= 1'b0;
            fill_idx_q  <= '0;
        end else begin
            if (take) begin
                if (fill_idx_q == IDX_W'(PAGE_WORDS - 1)) begin
                    full_q[fill_sel_q] <= 1'b1;
                    fill_sel_q         <= ~fill_sel_q;
                    fill_idx_q         <= '0;
                end else begin
                    fill_idx_q <= fill_idx_q + 1'b1;
                end
            end
            if (page_done) begin
                full_q[drain_sel_q] <= 1'b0;
                drain_sel_q         <= ~drain_sel_q;
            end
        end
    end

    AST_DRAIN_FULL: assert property (@(posedge clk) disable iff (rst)
        page_done |-> full_q[drain_sel_q]); // R4

endmodule

// File: rtl/nsw_sequencer.sv
module nsw_sequencer
    import nsw_pkg::*;
#(
    parameter int NUM_ROWS        = 4,
    parameter int NUM_LANES       = 2,
    parameter int PAGE_WORDS      = 8,
    parameter int NUM_BLOCKS      = 16,
    parameter int PAGES_PER_BLOCK = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             page_rdy,
    input  logic [NUM_LANES*LANE_W-1:0]      rd_data,
    output logic [clog2_min1(PAGE_WORDS)-1:0] rd_idx,
    output logic                             page_done,
    input  logic [NUM_BLOCKS-1:0]            bad_block_map,
    input  logic [NUM_ROWS-1:0]              flash_ready,
    output logic [NUM_ROWS-1:0]              flash_ce,
    output bus_ctl_t                         ctl,
    output logic [NUM_LANES*LANE_W-1:0]      flash_io
);
    localparam int ROW_W = clog2_min1(NUM_ROWS);
    localparam int IDX_W = clog2_min1(PAGE_WORDS);
    localparam int BLK_W = clog2_min1(NUM_BLOCKS);
    localparam int PG_W  = clog2_min1(PAGES_PER_BLOCK);

    seq_state_e        state_q;
    logic [ROW_W-1:0]  row_q;
    logic [PG_W-1:0]   page_q;
    logic [BLK_W-1:0]  blk_q;
    logic [IDX_W-1:0]  idx_q;
    logic [NUM_ROWS-1:0] wait_q;
    logic [NUM_ROWS-1:0] row_ready;
    logic [LANE_W-1:0] row_addr;
    logic              last_row, last_page;

    assign row_ready = flash_ready & ~wait_q;
    assign row_addr  = LANE_W'(int'(blk_q) * PAGES_PER_BLOCK + int'(page_q));
    assign last_row  = (row_q == ROW_W'(NUM_ROWS - 1));
    assign last_page = (page_q == PG_W'(PAGES_PER_BLOCK - 1));
    assign rd_idx    = idx_q;
    assign page_done = (state_q == ST_CONF);

    function automatic logic [BLK_W-1:0] next_good(input logic [BLK_W-1:0] cur,
                                                   input logic [NUM_BLOCKS-1:0] map);
        logic [BLK_W-1:0] pick;
        logic             found;
        pick  = cur;
        found = 1'b0;
        for (int k = 1; k <= NUM_BLOCKS; k++) begin
            int cand;
            cand = (int'(cur) + k) % NUM_BLOCKS;
            if (!found && !map[cand]) begin
                pick  = BLK_W'(cand);
                found = 1'b1;
            end
        end
        return pick;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
            page_q  <= '0;
            blk_q   <= '0;
            idx_q   <= '0;
            wait_q  <= '0;
        end else begin
            for (int r = 0; r < NUM_ROWS; r++) begin
                if (!flash_ready[r]) wait_q[r] <= 1'b0;
            end
            case (state_q)
                ST_IDLE: if (page_rdy && row_ready[row_q]) state_q <= ST_CMD;
                ST_CMD:  state_q <= ST_COL;
                ST_COL:  state_q <= ST_ROWA;
                ST_ROWA: begin
                    state_q <= ST_DATA;
                    idx_q   <= '0;
                end
                ST_DATA: begin
                    if (idx_q == IDX_W'(PAGE_WORDS - 1)) state_q <= ST_CONF;
                    else idx_q <= idx_q + 1'b1;
                end
                ST_CONF: begin
                    state_q       <= ST_IDLE;
                    wait_q[row_q] <= 1'b1;
                    row_q         <= last_row ? '0 : row_q + 1'b1;
                    if (last_row) begin
                        page_q <= last_page ? '0 : page_q + 1'b1;
                        if (last_page) blk_q <= next_good(blk_q, bad_block_map);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl      = '0;
        flash_io = '0;
        case (state_q)
            ST_CMD:  begin ctl = '{we: 1'b1, cle: 1'b1, ale: 1'b0}; flash_io = {NUM_LANES{OP_PROGRAM}}; end
            ST_COL:  begin ctl = '{we: 1'b1, cle: 1'b0, ale: 1'b1}; end
            ST_ROWA: begin ctl = '{we: 1'b1, cle: 1'b0, ale: 1'b1}; flash_io = {NUM_LANES{row_addr}}; end
            ST_DATA: begin ctl = '{we: 1'b1, cle: 1'b0, ale: 1'b0}; flash_io = rd_data; end
            ST_CONF: begin ctl = '{we: 1'b1, cle: 1'b1, ale: 1'b0}; flash_io = {NUM_LANES{OP_CONFIRM}}; end
            default: ;
        endcase
        flash_ce = (state_q != ST_IDLE) ? (NUM_ROWS'(1) << row_q) : '0;
    end

    AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flash_ce)); // R5
    AST_START_READY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CMD) |-> $past(row_ready[row_q])); // R6
    AST_SEQ_ORDER: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COL) |-> ($past(state_q) == ST_CMD)); // R2
    AST_BLK_GOOD: assert property (@(posedge clk) disable iff (rst)
        (blk_q != $past(blk_q)) |-> !bad_block_map[blk_q]); // R8

endmodule

// File: rtl/nand_stripe_writer.sv
module nand_stripe_writer
    import nsw_pkg::*;
#(
    parameter int NUM_ROWS        = 4,
    parameter int NUM_LANES       = 2,
    parameter int PAGE_WORDS      = 8,
    parameter int NUM_BLOCKS      = 16,
    parameter int PAGES_PER_BLOCK = 4,
    parameter int FIFO_DEPTH      = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [NUM_LANES*8-1:0]      in_data,
    input  logic [NUM_BLOCKS-1:0]       bad_block_map,
    input  logic [NUM_ROWS-1:0]         flash_ready,
    output logic [NUM_ROWS-1:0]         flash_ce,
    output logic                        flash_we,
    output logic                        flash_cle,
    output logic                        flash_ale,
    output logic [NUM_LANES*8-1:0]      flash_io,
    output logic                        overflow
);
    localparam int WORD_W = NUM_LANES * LANE_W;
    localparam int IDX_W  = clog2_min1(PAGE_WORDS);

    logic              q_valid, q_ready;
    logic [WORD_W-1:0] q_data, bank_data;
    logic [IDX_W-1:0]  bank_idx;
    logic              bank_rdy, bank_done;
    bus_ctl_t          ctl;

    nsw_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_level1 (
        .clk(clk), .rst(rst),
        .push_valid(in_valid), .push_data(in_data),
        .pop_valid(q_valid), .pop_data(q_data), .pop_ready(q_ready),
        .overflow(overflow)
    );

    nsw_pingpong #(.WIDTH(WORD_W), .PAGE_WORDS(PAGE_WORDS)) u_level2 (
        .clk(clk), .rst(rst),
        .wr_valid(q_valid), .wr_data(q_data), .wr_ready(q_ready),
        .rd_idx(bank_idx), .rd_data(bank_data),
        .page_rdy(bank_rdy), .page_done(bank_done)
    );

    nsw_sequencer #(
        .NUM_ROWS(NUM_ROWS), .NUM_LANES(NUM_LANES), .PAGE_WORDS(PAGE_WORDS),
        .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK)
    ) u_seq (
        .clk(clk), .rst(rst),
        .page_rdy(bank_rdy), .rd_data(bank_data), .rd_idx(bank_idx),
        .page_done(bank_done), .bad_block_map(bad_block_map),
        .flash_ready(flash_ready), .flash_ce(flash_ce),
        .ctl(ctl), .flash_io(flash_io)
    );

    assign flash_we  = ctl.we;
    assign flash_cle = ctl.cle;
    assign flash_ale = ctl.ale;

endmodule

// File: tb/nand_stripe_writer_tb.sv
`timescale 1ns/1ps
module nand_stripe_writer_tb;
    localparam int ROWS = 4, LANES = 2, PW = 8, BLOCKS = 16, PPB = 4, FDEPTH = 16;
    localparam int W = LANES * 8;
    localparam int BUSY = 30;

    logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic [BLOCKS-1:0] bad_map = '0;
    logic [ROWS-1:0] rb, ce;
    logic we, cle, ale, ovf;
    logic [W-1:0] io;

    int checks = 0, errors = 0;
    int busy_cnt [ROWS];
    bit hold_all = 1'b0;
    int extra_row = -1, extra_cyc = 0;
    logic [W-1:0] exp_q [$];
    int ph = 0, exp_row = 0, exp_page = 0, exp_blk = 0, pages_done = 0;
    logic [W-1:0] seq = '0;
    logic [7:0] ra;
    logic [W-1:0] ew;

    always #10 clk = ~clk;

    always_comb begin
        for (int r = 0; r < ROWS; r++) rb[r] = (busy_cnt[r] == 0) && !hold_all;
    end

    nand_stripe_writer u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .bad_block_map(bad_map), .flash_ready(rb), .flash_ce(ce),
        .flash_we(we), .flash_cle(cle), .flash_ale(ale), .flash_io(io),
        .overflow(ovf)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int nxt_blk(input int cur);
        for (int k = 1; k <= BLOCKS; k++) begin
            if (!bad_map[(cur + k) % BLOCKS]) return (cur + k) % BLOCKS;
        end
        return cur;
    endfunction

    // flash model and bus monitor
    always @(negedge clk) begin
        int setr;
        setr = -1;
        if (rst) begin
            ph = 0;
        end else if (we) begin
            if (ph == 0) begin
                chk(cle && !ale && io == {LANES{8'h80}}, "R2", "program command", io, {LANES{8'h80}});
                chk(ce == ROWS'(1 << exp_row), "R5", "row select", ce, 1 << exp_row);
                chk(busy_cnt[exp_row] == 0 && !hold_all, "R6", "row ready at start", busy_cnt[exp_row], 0);
                ph = 1;
            end else if (ph == 1) begin
                chk(ale && !cle && io == '0, "R2", "column address", io, 0);
                ph = 2;
            end else if (ph == 2) begin
                ra = 8'(exp_blk * PPB + exp_page);
                chk(ale && !cle && io == {LANES{ra}}, "R7 R8", "row address", io, {LANES{ra}});
                ph = 3;
            end else if (ph < 3 + PW) begin
                ew = (exp_q.size() > 0) ? exp_q.pop_front() : 'x;
                chk(!ale && !cle && io === ew, "R4", "data word", io, ew);
                ph++;
            end else begin
                chk(cle && !ale && io == {LANES{8'h10}}, "R2", "confirm command", io, {LANES{8'h10}});
                chk(ce == ROWS'(1 << exp_row), "R5", "confirm row", ce, 1 << exp_row);
                busy_cnt[exp_row] = BUSY + ((exp_row == extra_row) ? extra_cyc : 0);
                if (exp_row == extra_row) extra_row = -1;
                setr = exp_row;
                exp_row++;
                if (exp_row == ROWS) begin
                    exp_row = 0;
                    exp_page++;
                    if (exp_page == PPB) begin
                        exp_page = 0;
                        exp_blk = nxt_blk(exp_blk);
                    end
                end
                pages_done++;
                ph = 0;
            end
        end
        for (int r = 0; r < ROWS; r++) begin
            if (r != setr && busy_cnt[r] > 0) busy_cnt[r]--;
        end
    end

    task automatic do_reset(input bit hold);
        @(negedge clk); #1;
        rst = 1'b1;
        in_valid = 1'b0;
        hold_all = hold;
        for (int r = 0; r < ROWS; r++) busy_cnt[r] = 0;
        exp_q.delete();
        exp_row = 0; exp_page = 0; exp_blk = 0; pages_done = 0; extra_row = -1;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic stream(input int n, input int spacing, input int keep);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = seq;
            if (i < keep) exp_q.push_back(seq);
            seq++;
            for (int g = 1; g < spacing; g++) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_pages(input int n, input int limit, input string req);
        for (int c = 0; c < limit && pages_done < n; c++) @(negedge clk);
        chk(pages_done == n, req, "pages written", pages_done, n);
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        @(negedge clk);
        chk(!we && !cle && !ale, "R1", "bus strobes idle", {we, cle, ale}, 0);
        chk(ce == '0, "R1", "no row selected", ce, 0);
        chk(!ovf, "R1", "overflow clear", ovf, 0);
    endtask

    task automatic t_even_stream;
        do_reset(1'b0);
        bad_map = 16'h0006;
        extra_row = 1;
        extra_cyc = 40;
        seq = 16'h1000;
        stream(320, 2, 320);
        wait_pages(40, 3000, "R9");
        chk(!ovf, "R9", "no overflow at half rate", ovf, 0);
        chk(exp_q.size() == 0, "R4", "all words written", exp_q.size(), 0);
    endtask

    task automatic t_bursts;
        do_reset(1'b0);
        bad_map = 16'hFFFE;
        seq = 16'h4000;
        for (int b = 0; b < 7; b++) begin
            stream(3 * PW, 1, 3 * PW);
            repeat (60) @(negedge clk);
        end
        wait_pages(21, 2000, "R8");
        chk(!ovf, "R4", "no overflow in bursts", ovf, 0);
        chk(exp_q.size() == 0, "R4", "burst words written", exp_q.size(), 0);
    endtask

    task automatic t_stall;
        do_reset(1'b1);
        bad_map = '0;
        seq = 16'h8000;
        stream(2 * PW + FDEPTH, 1, 2 * PW + FDEPTH);
        chk(!ovf, "R10", "capacity reached without overflow", ovf, 0);
        repeat (20) @(negedge clk);
        chk(!we && pages_done == 0, "R10", "no bus cycle while all busy", pages_done, 0);
        #1 hold_all = 1'b0;
        wait_pages(4, 500, "R10");
        chk(exp_q.size() == 0, "R10", "stalled words written", exp_q.size(), 0);
    endtask

    task automatic t_overflow;
        do_reset(1'b1);
        seq = 16'hC000;
        stream(2 * PW + FDEPTH, 1, 2 * PW + FDEPTH);
        chk(!ovf, "R3", "no overflow before extra word", ovf, 0);
        stream(1, 1, 0);
        chk(ovf, "R3", "overflow after write to full queue", ovf, 1);
        #1 hold_all = 1'b0;
        wait_pages(4, 500, "R3");
        repeat (50) @(negedge clk);
        chk(pages_done == 4, "R3", "dropped word not written", pages_done, 4);
        chk(exp_q.size() == 0, "R3", "kept words written", exp_q.size(), 0);
        chk(ovf, "R3", "overflow sticky", ovf, 1);
        do_reset(1'b0);
        @(negedge clk);
        chk(!ovf, "R1", "reset clears overflow", ovf, 0);
    endtask

    initial begin
        for (int r = 0; r < ROWS; r++) busy_cnt[r] = 0;
        t_reset();
        t_even_stream();
        t_bursts();
        t_stall();
        t_overflow();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule